// File: doc/BRIEF.md
# Banked Interrupt Priority Register File

This block keeps the per-processor priority state of an interrupt controller's processor-side interface: an 8-bit priority mask, three 3-bit binary point registers (group 0, secure group 1 and non-secure group 1), and a set of 32-bit active-priority words for each of group 0, secure group 1 and non-secure group 1. Software reaches them through one register access port. Besides the selector, direction and data, each access carries its context: whether it comes from the non-secure world, the current exception level, whether the highest (monitor) exception level exists, whether FIQs are routed to that level, and two binary point sharing controls, one per security state.

The context changes what an access sees and what it may change. A non-secure view of the priority mask is a rescaled copy that cannot reach the secure half of the priority range. A group 1 binary point access can be redirected to, or aliased onto, the group 0 register. Some non-secure writes are dropped without any effect. Read data is combinational and is valid in the cycle of the read. Each write that actually changes state raises a one-cycle update strobe that tells the interrupt selection logic to re-evaluate.

Top module: `prio_bank_regs`

## Requirements
- R1: While reset is asserted (synchronous, active low), the mask clears to 0x00, the group 0 and secure group 1 binary points load 0, the non-secure group 1 binary point loads 1 if `has_el3` is high and 0 otherwise, every active-priority word clears to 0, and no update strobe is raised.
- R2: Selector codes are: mask 0, group 0 binary point 1, group 1 binary point 2, group 0 active words 3, group 1 active words 4. Without the non-secure view (defined in R3), a mask write stores `acc_wdata[7:0]` and a mask read returns the stored value zero-extended.
- R3: The non-secure view applies when `has_el3`, `acc_nonsec` and `fiq_to_el3` are all high. In that view, a mask read returns 0 if stored bit 7 is 0, returns 0xFF if the stored value is 0xFF, and returns the stored value shifted left by one (kept to 8 bits) otherwise.
- R4: In the non-secure view, a mask write is dropped if stored bit 7 is 0. Otherwise the mask becomes 0x80 OR (written byte shifted right by one).
- R5: A binary point write keeps only `acc_wdata[2:0]`. A group 1 binary point access uses the non-secure register when `acc_nonsec` is high and the secure register otherwise. A group 0 access always uses the group 0 register.
- R6: When `cbpr_sec` is high, a secure group 1 binary point access is redirected to the group 0 register, for both read and write, if it is below the monitor level (`acc_el` not 3) or if `acc_a32_nonmon` is high. A secure access at level 3 with `acc_a32_nonmon` low is not redirected.
- R7: When `cbpr_ns` is high, a non-secure group 1 binary point access below level 3 reads the group 0 value plus one, saturating at 7. Its write is dropped, and no binary point changes.
- R8: Active-priority words are indexed by `acc_idx`. Group 0 words are shared by both security states. Group 1 words have a separate bank for each security state.
- R9: When `has_el3` is high, non-secure writes to non-secure group 1 active words 0 and 1 are dropped. Words 2 and 3 stay writable. Without the monitor level, all four are writable.
- R10: `upd_strobe` is high for exactly the one cycle after each accepted write. It stays low after reads and after dropped writes.
- R11: `rd_data` is 0 whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Access request in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register selector (codes in R2) |
| acc_idx | input | 2 | Active-priority word index |
| acc_wdata | input | 32 | Write data |
| acc_nonsec | input | 1 | Access comes from the non-secure world |
| acc_el | input | 2 | Current exception level |
| acc_a32_nonmon | input | 1 | Level-3 access from 32-bit state outside monitor mode |
| has_el3 | input | 1 | Monitor exception level is implemented |
| fiq_to_el3 | input | 1 | FIQs are routed to the monitor level |
| cbpr_sec | input | 1 | Secure group 1 binary point shares the group 0 register |
| cbpr_ns | input | 1 | Non-secure group 1 binary point aliases group 0 plus one |
| rd_data | output | 32 | Combinational read data |
| upd_strobe | output | 1 | One-cycle pulse after an accepted write |

## Verification
Two functions can fall in the same cycle: the update strobe from a write, and a read of the register that write just changed. The bench provokes this by issuing a mask write and a mask read back to back. In the second cycle it checks that the strobe is high and that the read already returns the new value. Once that read has taken effect, it checks that the strobe has dropped. Reset arriving in the same cycle as a write is also tested: that write must leave no state and raise no strobe.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;

  localparam int PRIO_W    = 8;
  localparam int BP_W      = 3;
  localparam int NUM_BANKS = 3;

  typedef enum logic [2:0] {
    SEL_MASK   = 3'd0,
    SEL_BP_G0  = 3'd1,
    SEL_BP_G1  = 3'd2,
    SEL_ACT_G0 = 3'd3,
    SEL_ACT_G1 = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    BK_G0   = 2'd0,
    BK_G1S  = 2'd1,
    BK_G1NS = 2'd2
  } bank_e;

  // Non-secure picture of a stored mask.
  function automatic logic [PRIO_W-1:0] mask_view_ns(input logic [PRIO_W-1:0] v);
    if (!v[PRIO_W-1])       return '0;
    else if (&v)            return v;
    else                    return {v[PRIO_W-2:0], 1'b0};
  endfunction

  // Stored value produced by an accepted non-secure mask write.
  function automatic logic [PRIO_W-1:0] mask_store_ns(input logic [PRIO_W-1:0] w);
    return {1'b1, w[PRIO_W-1:1]};
  endfunction

  // Group 0 binary point plus one, held at the top value.
  function automatic logic [BP_W-1:0] bp_sat_inc(input logic [BP_W-1:0] b);
    return (&b) ? b : b + 1'b1;
  endfunction

endpackage

// File: rtl/prio_mask_reg.sv
module prio_mask_reg
  import prio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              ns_view,
  input  logic [PRIO_W-1:0] wdata,
  output logic [PRIO_W-1:0] rd_val,
  output logic              accepted
);

  logic [PRIO_W-1:0] mask_q;
  logic              secure_half;
  logic              ns_locked;
  logic [PRIO_W-1:0] mask_d;

  assign secure_half = ~mask_q[PRIO_W-1];
  assign ns_locked   = ns_view && secure_half;
  assign accepted    = wr_en && !ns_locked;
  assign mask_d      = ns_view ? mask_store_ns(wdata) : wdata;
  assign rd_val      = ns_view ? mask_view_ns(mask_q) : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        mask_q <= '0;
    else if (accepted) mask_q <= mask_d;
  end

  a_r4_ns_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ns_locked) |=> $stable(mask_q));

  a_r4_ns_write_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ns_view && !secure_half) |=> mask_q[PRIO_W-1]);

  a_r1_mask_reset: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '0));

endmodule

// File: rtl/binpt_bank.sv
module binpt_bank
  import prio_bank_pkg::*;
#(
  parameter int BP_MIN    = 0,
  parameter int BP_MIN_NS = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            has_el3,
  input  logic            wr_en,
  input  logic            is_g1,
  input  logic            nonsec,
  input  logic            below_el3,
  input  logic            a32_nonmon,
  input  logic            cbpr_sec,
  input  logic            cbpr_ns,
  input  logic [BP_W-1:0] wdata,
  output logic [BP_W-1:0] rd_val,
  output logic            accepted
);

  localparam logic [BP_W-1:0] MIN_C    = BP_W'(BP_MIN);
  localparam logic [BP_W-1:0] MIN_NS_C = BP_W'(BP_MIN_NS);

  logic [BP_W-1:0] bp_q [NUM_BANKS];
  logic            ns_alias;
  logic            s_redirect;
  bank_e           target;

  assign ns_alias   = is_g1 && nonsec && cbpr_ns && below_el3;
  assign s_redirect = is_g1 && !nonsec && cbpr_sec && (below_el3 || a32_nonmon);

  always_comb begin
    if (!is_g1 || s_redirect) target = BK_G0;
    else if (nonsec)          target = BK_G1NS;
    else                      target = BK_G1S;
  end

  assign rd_val   = ns_alias ? bp_sat_inc(bp_q[BK_G0]) : bp_q[int'(target)];
  assign accepted = wr_en && !ns_alias;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++)
        bp_q[b] <= (b == int'(BK_G1NS) && has_el3) ? MIN_NS_C : MIN_C;
    end else if (accepted) begin
      bp_q[int'(target)] <= wdata;
    end
  end

  a_r7_alias_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ns_alias) |=> ($stable(bp_q[BK_G0]) && $stable(bp_q[BK_G1NS]) && $stable(bp_q[BK_G1S])));

  a_r6_redirect_spares_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && s_redirect) |=> $stable(bp_q[BK_G1S]));

  a_r5_ns_write_spares_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_g1 && nonsec) |=> $stable(bp_q[BK_G1S]));

endmodule

// File: rtl/active_prio_bank.sv
module active_prio_bank
  import prio_bank_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_WORDS  = 4,
  parameter int LOCK_WORDS = 2,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              has_el3,
  input  logic              wr_en,
  input  logic              is_g1,
  input  logic              nonsec,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic              accepted
);

  logic [DATA_W-1:0] word_q [NUM_BANKS][NUM_WORDS];
  bank_e             bank;
  logic              lock_hit;

  always_comb begin
    if (!is_g1)      bank = BK_G0;
    else if (nonsec) bank = BK_G1NS;
    else             bank = BK_G1S;
  end

  assign lock_hit = is_g1 && nonsec && has_el3 && (int'(idx) < LOCK_WORDS);
  assign accepted = wr_en && !lock_hit;
  assign rd_val   = word_q[int'(bank)][int'(idx)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int w = 0; w < NUM_WORDS; w++)
          word_q[b][w] <= '0;
    end else if (accepted) begin
      word_q[int'(bank)][int'(idx)] <= wdata;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word_chk
    a_r9_locked_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock_hit && int'(idx) == w) |=> $stable(word_q[BK_G1NS][w]));
    a_r8_bank_separation: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_g1 && !nonsec) |=> $stable(word_q[BK_G1NS][w]));
  end

endmodule

// File: rtl/prio_bank_regs.sv
module prio_bank_regs
  import prio_bank_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_WORDS  = 4,
  parameter int LOCK_WORDS = 2,
  parameter int BP_MIN     = 0,
  parameter int BP_MIN_NS  = 1,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [2:0]        acc_sel,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_nonsec,
  input  logic [1:0]        acc_el,
  input  logic              acc_a32_nonmon,
  input  logic              has_el3,
  input  logic              fiq_to_el3,
  input  logic              cbpr_sec,
  input  logic              cbpr_ns,
  output logic [DATA_W-1:0] rd_data,
  output logic              upd_strobe
);

  reg_sel_e          sel;
  logic              wr_any;
  logic              rd_any;
  logic              below_el3;
  logic              ns_view;
  logic              wr_mask, wr_bp, wr_act;
  logic              acc_mask, acc_bp, acc_act;
  logic              write_accepted;
  logic [PRIO_W-1:0] mask_rd;
  logic [BP_W-1:0]   bp_rd;
  logic [DATA_W-1:0] act_rd;
  logic              strobe_q;

  assign sel       = reg_sel_e'(acc_sel);
  assign wr_any    = acc_valid && acc_write;
  assign rd_any    = acc_valid && !acc_write;
  assign below_el3 = (acc_el != 2'd3);
  assign ns_view   = has_el3 && acc_nonsec && fiq_to_el3;

  assign wr_mask = wr_any && (sel == SEL_MASK);
  assign wr_bp   = wr_any && (sel == SEL_BP_G0 || sel == SEL_BP_G1);
  assign wr_act  = wr_any && (sel == SEL_ACT_G0 || sel == SEL_ACT_G1);

  prio_mask_reg u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_mask),
    .ns_view  (ns_view),
    .wdata    (acc_wdata[PRIO_W-1:0]),
    .rd_val   (mask_rd),
    .accepted (acc_mask)
  );

  binpt_bank #(
    .BP_MIN    (BP_MIN),
    .BP_MIN_NS (BP_MIN_NS)
  ) u_binpt (
    .clk        (clk),
    .rst_n      (rst_n),
    .has_el3    (has_el3),
    .wr_en      (wr_bp),
    .is_g1      (sel == SEL_BP_G1),
    .nonsec     (acc_nonsec),
    .below_el3  (below_el3),
    .a32_nonmon (acc_a32_nonmon),
    .cbpr_sec   (cbpr_sec),
    .cbpr_ns    (cbpr_ns),
    .wdata      (acc_wdata[BP_W-1:0]),
    .rd_val     (bp_rd),
    .accepted   (acc_bp)
  );

  active_prio_bank #(
    .DATA_W     (DATA_W),
    .NUM_WORDS  (NUM_WORDS),
    .LOCK_WORDS (LOCK_WORDS)
  ) u_active (
    .clk      (clk),
    .rst_n    (rst_n),
    .has_el3  (has_el3),
    .wr_en    (wr_act),
    .is_g1    (sel == SEL_ACT_G1),
    .nonsec   (acc_nonsec),
    .idx      (acc_idx),
    .wdata    (acc_wdata),
    .rd_val   (act_rd),
    .accepted (acc_act)
  );

  assign write_accepted = acc_mask || acc_bp || acc_act;

  always_comb begin
    rd_data = '0;
    if (rd_any) begin
      unique case (sel)
        SEL_MASK:              rd_data = DATA_W'(mask_rd);
        SEL_BP_G0, SEL_BP_G1:  rd_data = DATA_W'(bp_rd);
        SEL_ACT_G0, SEL_ACT_G1: rd_data = act_rd;
        default:               rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= write_accepted;
  end

  assign upd_strobe = strobe_q;

  a_r10_no_strobe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> !upd_strobe);

  a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && !write_accepted) |=> !upd_strobe);

  a_r10_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    write_accepted |=> upd_strobe);

  always_comb begin
    if (!acc_valid) a_r11_idle_zero: assert (rd_data == '0);
  end

endmodule

// File: tb/prio_bank_regs_bench.sv
module prio_bank_regs_bench;

  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] S_MK = 3'd0;
  localparam logic [2:0] S_B0 = 3'd1;
  localparam logic [2:0] S_B1 = 3'd2;
  localparam logic [2:0] S_A0 = 3'd3;
  localparam logic [2:0] S_A1 = 3'd4;

  typedef struct packed {
    logic        wr;
    logic [2:0]  sel;
    logic [1:0]  idx;
    logic        ns;
    logic [1:0]  el;
    logic        a32;
    logic        el3;
    logic        fiq;
    logic        cbs;
    logic        cbn;
    logic [31:0] data;
    logic [31:0] exp;   // read value, or expected strobe for a write
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{1'b0,S_MK,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h00,4'd1},        // R1 mask reset
    '{1'b0,S_B1,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h01,4'd1},        // R1 ns bp reset
    '{1'b1,S_MK,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h55,32'h0,4'd4},        // R4 dropped
    '{1'b0,S_MK,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h00,4'd4},        // R4 unchanged
    '{1'b1,S_MK,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'hFFA4,32'h1,4'd2},      // R2
    '{1'b0,S_MK,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'hA4,4'd2},        // R2
    '{1'b0,S_MK,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h48,4'd3},        // R3 shifted
    '{1'b1,S_MK,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h60,32'h1,4'd4},        // R4 accepted
    '{1'b0,S_MK,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'hB0,4'd4},        // R4 stored
    '{1'b1,S_MK,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'hFF,32'h1,4'd2},        // R2
    '{1'b0,S_MK,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'hFF,4'd3},        // R3 all ones
    '{1'b1,S_MK,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h40,32'h1,4'd2},        // R2
    '{1'b0,S_MK,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h00,4'd3},        // R3 secure half hidden
    '{1'b0,S_MK,2'd0,1'b1,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,32'h40,4'd3},        // R3 no view without fiq
    '{1'b1,S_B0,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'hFD,32'h1,4'd5},        // R5
    '{1'b0,S_B0,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h05,4'd5},        // R5 low bits
    '{1'b1,S_B1,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0A,32'h1,4'd5},        // R5
    '{1'b0,S_B1,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h01,4'd5},        // R5 banked
    '{1'b1,S_B1,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h06,32'h1,4'd5},        // R5
    '{1'b0,S_B1,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h02,4'd5},        // R5 secure kept
    '{1'b0,S_B1,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b1,1'b0,32'h0,32'h05,4'd6},        // R6 redirect read
    '{1'b1,S_B1,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b1,1'b0,32'h03,32'h1,4'd6},        // R6 redirect write
    '{1'b0,S_B0,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h03,4'd6},        // R6 group 0 changed
    '{1'b0,S_B1,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h02,4'd6},        // R6 secure untouched
    '{1'b0,S_B1,2'd0,1'b0,2'd3,1'b0,1'b1,1'b1,1'b1,1'b0,32'h0,32'h02,4'd6},        // R6 level 3 no redirect
    '{1'b0,S_B1,2'd0,1'b0,2'd3,1'b1,1'b1,1'b1,1'b1,1'b0,32'h0,32'h03,4'd6},        // R6 32-bit non-monitor
    '{1'b0,S_B1,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b1,32'h0,32'h04,4'd7},        // R7 plus one
    '{1'b1,S_B1,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b1,32'h0,32'h0,4'd7},         // R7 dropped
    '{1'b0,S_B1,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h06,4'd7},        // R7 ns kept
    '{1'b1,S_B0,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h07,32'h1,4'd5},        // R5
    '{1'b0,S_B1,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b1,32'h0,32'h07,4'd7},        // R7 saturates
    '{1'b1,S_A0,2'd2,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'hDEADBEEF,32'h1,4'd8},  // R8
    '{1'b0,S_A0,2'd2,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'hDEADBEEF,4'd8},  // R8 shared
    '{1'b1,S_A1,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h11111111,32'h1,4'd8},  // R8
    '{1'b0,S_A1,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h0,4'd8},         // R8 banked
    '{1'b1,S_A1,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h2222,32'h0,4'd9},      // R9 word 0 locked
    '{1'b0,S_A1,2'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h0,4'd9},         // R9
    '{1'b1,S_A1,2'd1,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h3,32'h0,4'd9},         // R9 word 1 locked
    '{1'b1,S_A1,2'd3,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h33334444,32'h1,4'd9},  // R9 word 3 open
    '{1'b0,S_A1,2'd3,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h33334444,4'd9},  // R9
    '{1'b0,S_A1,2'd3,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h0,4'd8},         // R8
    '{1'b0,S_A1,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,32'h11111111,4'd8},  // R8
    '{1'b1,S_A1,2'd0,1'b1,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h5555,32'h1,4'd9},      // R9 no monitor level
    '{1'b0,S_A1,2'd0,1'b1,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,32'h5555,4'd9}       // R9
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [2:0]  acc_sel;
  logic [1:0]  acc_idx;
  logic [31:0] acc_wdata;
  logic        acc_nonsec;
  logic [1:0]  acc_el;
  logic        acc_a32_nonmon;
  logic        has_el3, fiq_to_el3, cbpr_sec, cbpr_ns;
  logic [31:0] rd_data;
  logic        upd_strobe;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_bank_regs u_prio_bank_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
    .acc_nonsec(acc_nonsec), .acc_el(acc_el), .acc_a32_nonmon(acc_a32_nonmon),
    .has_el3(has_el3), .fiq_to_el3(fiq_to_el3), .cbpr_sec(cbpr_sec),
    .cbpr_ns(cbpr_ns), .rd_data(rd_data), .upd_strobe(upd_strobe)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h, expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    acc_valid = 1'b1; acc_write = v.wr; acc_sel = v.sel; acc_idx = v.idx;
    acc_nonsec = v.ns; acc_el = v.el; acc_a32_nonmon = v.a32; has_el3 = v.el3;
    fiq_to_el3 = v.fiq; cbpr_sec = v.cbs; cbpr_ns = v.cbn; acc_wdata = v.data;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_sel = S_MK; acc_idx = '0;
    acc_wdata = '0; acc_nonsec = 1'b0; acc_el = 2'd1; acc_a32_nonmon = 1'b0;
    has_el3 = 1'b1; fiq_to_el3 = 1'b1; cbpr_sec = 1'b0; cbpr_ns = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: nothing requested, read data is zero
    #1 check(rd_data, 32'h0, "R11 idle read data");
    check({31'b0, upd_strobe}, 32'h0, "R1 no strobe after reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      if (!VEC[i].wr) check(rd_data, VEC[i].exp, $sformatf("R%0d vector %0d read", VEC[i].req, i));
      @(negedge clk);
      acc_valid = 1'b0;
      if (VEC[i].wr) check({31'b0, upd_strobe}, VEC[i].exp, $sformatf("R%0d vector %0d strobe", VEC[i].req, i));
    end

    // R10: write followed at once by a read of the same register
    @(negedge clk);
    drive('{1'b1,S_MK,2'd0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h9C,32'h0,4'd10});
    @(negedge clk);
    acc_write = 1'b0;
    #1;
    check({31'b0, upd_strobe}, 32'h1, "R10 strobe with back-to-back read");
    check(rd_data, 32'h9C, "R2 read sees write in strobe cycle");
    @(negedge clk);
    acc_valid = 1'b0;
    check({31'b0, upd_strobe}, 32'h0, "R10 strobe lasts one cycle");

    // R1: reset wins over a write in the same cycle; reset value without monitor level
    @(negedge clk);
    drive('{1'b1,S_MK,2'd0,1'b0,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h12,32'h0,4'd1});
    rst_n = 1'b0;
    @(negedge clk);
    acc_valid = 1'b0;
    check({31'b0, upd_strobe}, 32'h0, "R1 no strobe under reset");
    @(negedge clk);
    rst_n = 1'b1;
    drive('{1'b0,S_MK,2'd0,1'b0,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,32'h0,4'd1});
    #1 check(rd_data, 32'h0, "R1 mask cleared by reset");
    @(negedge clk);
    drive('{1'b0,S_B1,2'd0,1'b1,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,32'h0,4'd1});
    #1 check(rd_data, 32'h0, "R1 ns binary point without monitor level");
    @(negedge clk);
    drive('{1'b0,S_A0,2'd2,1'b0,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,32'h0,4'd1});
    #1 check(rd_data, 32'h0, "R1 active word cleared");
    @(negedge clk);
    acc_valid = 1'b0;

    done = 1'b1;
    finish_run();
  end

endmodule